// File: doc/BRIEF.md
# Multi-mode transceiver test pattern generator

A transmit-side self-test source for a serial link that emits one symbol per clock. A 3-bit mode input chooses what it sends: a pseudo-random word stream, a framed sweep of control and data characters, or one of three constant tone characters (fast toggling, slow toggling, or mixed). The pseudo-random stream is sent as raw 8-bit or 10-bit words, with the width set by a parameter. Those words carry a flag that tells the downstream line coder to pass them through unencoded. In every other mode the block emits an 8-bit character in the low bits of the symbol bus, plus a control-character flag, ready for an 8b/10b encoder.

The mode is captured only while the synchronous reset is high. Each reset restarts the selected pattern from its first symbol. The encoder, the serializer, loopback and line measurement live outside this block.

Top module: `selftest_pattern_gen`

## Requirements
- R1: While `rst` is high the block captures `mode`. In the first cycle after `rst` falls it presents the pattern's first symbol: all ones in mode 0, and 0xBC with `is_ctrl`=1 in mode 1.
- R2: With `PRBS_W`=8, mode 0 emits the successive states of an LFSR. Each new state is the old one shifted left one bit, with bit 0 = s[7]^s[6]^s[4]^s[2] (polynomial x^8+x^7+x^5+x^3+1). All ones recurs after exactly 255 symbols.
- R3: With `PRBS_W`=10, mode 0 uses new bit 0 = s[9]^s[6] (x^10+x^7+1). All ones recurs after exactly 1023 symbols, and the state is never zero.
- R4: In mode 0, `bypass_code`=1 and `is_ctrl`=0. In every other mode, `bypass_code`=0.
- R5: Mode 1 emits, in order: 0xBC, 0xFB, data 0x00 to 0xFF ascending, then 0x1C, 0x3C, 0x5C, 0x7C, 0x9C, 0xDC, 0xFC, 0xF7, 0xFE, 0xFD. `is_ctrl`=1 on every non-data symbol and 0 on data. Upper symbol bits above bit 7 are zero.
- R6: Mode 1 repeats with period 268: 0xFD is followed by 0xBC.
- R7: Mode 2 emits 0xB5 with `is_ctrl`=0 on every cycle.
- R8: Mode 3 emits 0xFC with `is_ctrl`=1 on every cycle.
- R9: Mode 4 emits 0xBC with `is_ctrl`=1 on every cycle.
- R10: A change of `mode` while `rst` is low has no effect on the outputs.
- R11: Modes 5 to 7 emit symbol 0 with `is_ctrl`=0 and `bypass_code`=0.
- R12: A reset in the middle of a pattern restarts it at its first symbol.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Symbol clock |
| rst | input | 1 | Synchronous reset, active high; mode is sampled while high |
| mode | input | 3 | Pattern select: 0 PRBS, 1 sweep, 2 fast tone, 3 slow tone, 4 mixed tone |
| sym | output | PRBS_W | Symbol; characters occupy bits 7:0 |
| is_ctrl | output | 1 | Symbol is a control character |
| bypass_code | output | 1 | Symbol must skip 8b/10b encoding |

## Verification
Directed runs walk a full PRBS period at both widths, checking both the exact recurrence of all ones and the absence of any earlier recurrence. They also walk two full laps of the sweep, which separates ordering, K-flag and wrap faults. Randomly chosen modes, including the reserved codes, are run for random lengths, and each run begins with a reset. These runs mix mid-pattern restarts with every mode and tell apart faults in the mode mux, the flags and the restart. A directed step changes `mode` without a reset to show the captured mode holds.

// File: rtl/selftest_pattern_gen.sv
module selftest_pattern_gen #(
  parameter int PRBS_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        mode,
  output logic [PRBS_W-1:0] sym,
  output logic              is_ctrl,
  output logic              bypass_code
);
  localparam int SEQ_LEN  = 268;
  localparam int IW       = $clog2(SEQ_LEN);
  localparam int TAIL_AT  = 258;

  logic [2:0]        mode_q;
  logic [PRBS_W-1:0] lfsr;
  logic [IW-1:0]     idx;
  logic              fb;
  logic [7:0]        chr;
  logic              chr_k;
  logic [IW-1:0]     tail;

  generate
    if (PRBS_W == 10) begin : g_w10
      assign fb = lfsr[9] ^ lfsr[6];
    end else begin : g_w8
      assign fb = lfsr[7] ^ lfsr[6] ^ lfsr[4] ^ lfsr[2];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= mode;
      lfsr   <= '1;
      idx    <= '0;
    end else begin
      lfsr <= {lfsr[PRBS_W-2:0], fb};
      idx  <= (idx == IW'(SEQ_LEN-1)) ? '0 : idx + 1'b1;
    end
  end

  assign tail = idx - IW'(TAIL_AT);

  always_comb begin
    chr   = 8'h00;
    chr_k = 1'b0;
    case (mode_q)
      3'd1: begin
        if (idx == '0) begin
          chr = 8'hBC; chr_k = 1'b1;
        end else if (idx == IW'(1)) begin
          chr = 8'hFB; chr_k = 1'b1;
        end else if (idx < IW'(TAIL_AT)) begin
          chr = idx[7:0] - 8'd2;
        end else begin
          chr_k = 1'b1;
          case (tail)
            IW'(0): chr = 8'h1C;
            IW'(1): chr = 8'h3C;
            IW'(2): chr = 8'h5C;
            IW'(3): chr = 8'h7C;
            IW'(4): chr = 8'h9C;
            IW'(5): chr = 8'hDC;
            IW'(6): chr = 8'hFC;
            IW'(7): chr = 8'hF7;
            IW'(8): chr = 8'hFE;
            default: chr = 8'hFD;
          endcase
        end
      end
      3'd2: chr = 8'hB5;
      3'd3: begin chr = 8'hFC; chr_k = 1'b1; end
      3'd4: begin chr = 8'hBC; chr_k = 1'b1; end
      default: ;
    endcase
  end

  assign bypass_code = (mode_q == 3'd0);
  assign is_ctrl     = bypass_code ? 1'b0 : chr_k;
  assign sym         = bypass_code ? lfsr : {{(PRBS_W-8){1'b0}}, chr};

  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (rst)
    lfsr != '0); // R3
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $stable(mode_q)); // R10
  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (rst)
    idx < IW'(SEQ_LEN)); // R6
  AST_SWEEP_WRAP: assert property (@(posedge clk) disable iff (rst)
    (mode_q == 3'd1 && sym[7:0] == 8'hFD && is_ctrl) |=> (sym[7:0] == 8'hBC && is_ctrl)); // R6
  AST_BYPASS_NO_K: assert property (@(posedge clk) disable iff (rst)
    !(bypass_code && is_ctrl)); // R4
endmodule

// File: tb/tb_selftest_pattern_gen.sv
module tb_selftest_pattern_gen;
  logic clk = 0, rst = 1;
  logic [2:0] mode = 0;
  logic [7:0] sym8;
  logic [9:0] sym10;
  logic k8, b8, k10, b10;
  int errors = 0, checks = 0;

  always #5 clk = ~clk;

  selftest_pattern_gen #(.PRBS_W(8)) dut (.clk(clk), .rst(rst), .mode(mode),
    .sym(sym8), .is_ctrl(k8), .bypass_code(b8));
  selftest_pattern_gen #(.PRBS_W(10)) dut10 (.clk(clk), .rst(rst), .mode(mode),
    .sym(sym10), .is_ctrl(k10), .bypass_code(b10));

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] step8(logic [7:0] s);
    return {s[6:0], s[7] ^ s[6] ^ s[4] ^ s[2]};
  endfunction
  function automatic logic [9:0] step10(logic [9:0] s);
    return {s[8:0], s[9] ^ s[6]};
  endfunction

  function automatic logic [8:0] sweep(int i);
    int t;
    if (i == 0) return {1'b1, 8'hBC};
    if (i == 1) return {1'b1, 8'hFB};
    if (i < 258) return {1'b0, 8'(i - 2)};
    t = i - 258;
    case (t)
      0: return {1'b1, 8'h1C};
      1: return {1'b1, 8'h3C};
      2: return {1'b1, 8'h5C};
      3: return {1'b1, 8'h7C};
      4: return {1'b1, 8'h9C};
      5: return {1'b1, 8'hDC};
      6: return {1'b1, 8'hFC};
      7: return {1'b1, 8'hF7};
      8: return {1'b1, 8'hFE};
      default: return {1'b1, 8'hFD};
    endcase
  endfunction

  function automatic logic [8:0] expect_chr(logic [2:0] m, int i);
    case (m)
      3'd1: return sweep(i % 268);
      3'd2: return {1'b0, 8'hB5};
      3'd3: return {1'b1, 8'hFC};
      3'd4: return {1'b1, 8'hBC};
      default: return 9'h0;
    endcase
  endfunction

  function automatic string tag(logic [2:0] m);
    case (m)
      3'd0: return "R2";
      3'd1: return "R5";
      3'd2: return "R7";
      3'd3: return "R8";
      3'd4: return "R9";
      default: return "R11";
    endcase
  endfunction

  task automatic do_reset(input logic [2:0] m);
    @(negedge clk);
    rst = 1; mode = m;
    @(posedge clk);
    @(negedge clk);
    rst = 0;
  endtask

  task automatic run_mode(input logic [2:0] m, input int n, input string extra);
    logic [7:0] e8 = '1;
    logic [9:0] e10 = '1;
    logic [8:0] ec;
    do_reset(m);
    for (int i = 0; i < n; i++) begin
      if (m == 3'd0) begin
        chk(sym8 == e8, {tag(m), extra}, 16'(sym8), 16'(e8));
        chk(sym10 == e10, {"R3", extra}, 16'(sym10), 16'(e10));
        chk(b8 && !k8 && b10 && !k10, {"R4", extra}, {12'h0, b8, k8, b10, k10}, 16'hA);
      end else begin
        ec = expect_chr(m, i);
        chk({k8, sym8} == ec, {tag(m), extra}, {7'h0, k8, sym8}, 16'(ec));
        chk({k10, sym10} == {ec[8], 2'b00, ec[7:0]}, {tag(m), extra}, {5'h0, k10, sym10}, 16'(ec));
        chk(!b8 && !b10, {"R4", extra}, {14'h0, b8, b10}, 16'h0);
      end
      e8 = step8(e8);
      e10 = step10(e10);
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int seen8, seen10;
    logic [2:0] rm;
    void'($urandom(32'd1234));

    // R1: first symbol after reset
    do_reset(3'd0);
    chk(sym8 == 8'hFF && sym10 == 10'h3FF, "R1", 16'(sym8), 16'hFF);
    do_reset(3'd1);
    chk(sym8 == 8'hBC && k8, "R1", {7'h0, k8, sym8}, 16'h1BC);

    // R2/R3: exact period of both LFSR widths
    do_reset(3'd0);
    seen8 = 0; seen10 = 0;
    for (int i = 1; i <= 1023; i++) begin
      @(posedge clk); @(negedge clk);
      if (sym8 == 8'hFF && seen8 == 0) seen8 = i;
      if (sym10 == 10'h3FF && seen10 == 0) seen10 = i;
      if (sym10 == 10'h0) chk(0, "R3 zero state", 16'(sym10), 16'h3FF);
    end
    chk(seen8 == 255, "R2 period", 16'(seen8), 16'd255);
    chk(seen10 == 1023, "R3 period", 16'(seen10), 16'd1023);

    // R5/R6: two full laps of the sweep
    run_mode(3'd1, 2 * 268 + 3, " R6 sweep laps");

    // R12: restart mid pattern
    run_mode(3'd1, 40, "");
    run_mode(3'd1, 5, " R12 restart");
    run_mode(3'd0, 17, "");
    run_mode(3'd0, 5, " R12 restart");

    // R10: mode changed without reset is ignored
    do_reset(3'd2);
    mode = 3'd0;
    for (int i = 0; i < 5; i++) begin
      @(posedge clk); @(negedge clk);
      chk(sym8 == 8'hB5 && !k8 && !b8, "R10", {6'h0, b8, k8, sym8}, 16'hB5);
    end

    // tones and reserved codes, directed
    for (int m = 2; m < 8; m++) run_mode(3'(m), 6, "");

    // random modes and run lengths
    for (int r = 0; r < 24; r++) begin
      rm = 3'($urandom_range(0, 7));
      run_mode(rm, $urandom_range(1, 300), " R12 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule